// File: doc/BRIEF.md
# Watchdog Clock Loss Monitor

This block watches a slow external reference clock, nominally 32 kHz, from a fast free-running system clock. The reference also paces the overload and short-circuit delay timers elsewhere in the protection logic. If its edges stop, those timers freeze. The block raises two indications when that happens: a live timebase-valid flag and a latched fault.

The reference passes through a synchronizer chain, and a rising-edge detector follows it. A saturating counter restarts on every detected edge. Once the counter reaches a timeout of several nominal periods, the timebase-valid flag drops. Unless monitoring is disabled, the fault latch then sets. The fault stays set until the clear control bit completes a full raise-and-return sequence. A clear issued while the reference is still absent restarts the timeout window, so the fault comes back one timeout later.

The control bits come from a register interface that is not part of this block. They are assumed to be synchronous to the system clock.

Top module: `wdt_clk_monitor`

## Requirements
- R1: In reset and on the first cycle after reset, `wd_fault_o` is 0 and `tmr_clk_valid_o` is 1.
- R2: While the reference toggles with a period well below the timeout, `wd_fault_o` stays 0 and `tmr_clk_valid_o` stays 1.
- R3: Let the reference rise in system cycle n, i.e. it is first sampled at edge n+1. With no later rise, `tmr_clk_valid_o` is 1 through cycle n+2+TIMEOUT_CYC and drops to 0 at cycle n+3+TIMEOUT_CYC. This timing comes from two synchronizer stages, one edge register and the counter.
- R4: When `tmr_clk_valid_o` is 0 and `wd_dis_i` is 0, `wd_fault_o` becomes 1 on the next cycle. This holds both for the first expiry and when monitoring is re-enabled while the timeout has already elapsed.
- R5: Once set, `wd_fault_o` stays 1 after the reference resumes, and `tmr_clk_valid_o` returns to 1.
- R6: The fault is cleared only when `wd_clr_i` returns from 1 to 0: `wd_fault_o` reads 0 on the cycle after the falling edge. Holding `wd_clr_i` at 1 leaves the fault set.
- R7: While `wd_dis_i` is 1, no new fault is raised, but `tmr_clk_valid_o` still drops on timeout.
- R8: Raising `wd_dis_i` does not clear a fault that is already set.
- R9: A clear while the reference is absent takes effect for one timeout window. The fault reads 0 from the cycle after the clear. `tmr_clk_valid_o` is 1 again and drops TIMEOUT_CYC+1 cycles after the clear cycle. The fault sets again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wd_clk_i | input | 1 | Monitored reference clock, asynchronous |
| wd_dis_i | input | 1 | 1 suppresses raising the fault |
| wd_clr_i | input | 1 | Clear control bit; a 1-to-0 return clears the fault |
| wd_fault_o | output | 1 | Latched clock-loss fault |
| tmr_clk_valid_o | output | 1 | Timebase present; 0 once the timeout has elapsed |

## Verification
A reference rise driven in cycle n restarts the counter at cycle n+3. Without another rise, the valid flag falls at n+3+TIMEOUT_CYC and the fault follows one cycle later. A clear's falling edge in cycle m shows on the fault at m+1, and changing the disable input affects the fault one cycle later. The driver computes each of these due cycles from a shared cycle counter at the moment it applies the stimulus, and queues the expected output values against them. The monitor samples on the falling clock edge and compares only entries whose due cycle matches. An entry that is skipped is counted as a failure.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
  function automatic int unsigned timeout_cycles(int unsigned sys_hz,
                                                 int unsigned ref_hz,
                                                 int unsigned periods);
    return (sys_hz / ref_hz) * periods;
  endfunction
endpackage

// File: rtl/wdm_sync.sv
module wdm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain[g] <= 1'b0;
        else         chain[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain[g] <= 1'b0;
        else         chain[g] <= chain[g-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/wdm_edge.sv
module wdm_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/wdm_timeout.sv
module wdm_timeout #(
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt_q;

  // saturates at LIMIT so expiry persists until an edge arrives
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= '0;
    else if (cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;

  assign expired_o = (cnt_q == LIMIT);
endmodule

// File: rtl/wdt_clk_monitor.sv
module wdt_clk_monitor #(
  parameter int unsigned SYS_CLK_HZ      = 200_000_000,
  parameter int unsigned REF_CLK_HZ      = 32_768,
  parameter int unsigned TIMEOUT_PERIODS = 4,
  parameter int unsigned TIMEOUT_CYC     =
      wdm_pkg::timeout_cycles(SYS_CLK_HZ, REF_CLK_HZ, TIMEOUT_PERIODS),
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wd_clk_i,
  input  logic wd_dis_i,
  input  logic wd_clr_i,
  output logic wd_fault_o,
  output logic tmr_clk_valid_o
);
  logic wd_sync;
  logic wd_rise;
  logic wd_fall_unused;
  logic clr_rise_unused;
  logic clr_pulse;
  logic expired;
  logic fault_q;

  wdm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wd_clk_i),
    .q_o   (wd_sync)
  );

  wdm_edge u_ref_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(wd_sync),
    .rise_o (wd_rise),
    .fall_o (wd_fall_unused)
  );

  // clear control is register-domain; its return to 0 ends the sequence
  wdm_edge u_clr_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(wd_clr_i),
    .rise_o (clr_rise_unused),
    .fall_o (clr_pulse)
  );

  // a clear also restarts the window so a dead clock re-faults after one timeout
  wdm_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timeout (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(wd_rise | clr_pulse),
    .expired_o(expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                    fault_q <= 1'b0;
    else if (clr_pulse)             fault_q <= 1'b0;
    else if (expired && !wd_dis_i)  fault_q <= 1'b1;

  assign wd_fault_o      = fault_q;
  assign tmr_clk_valid_o = ~expired;
endmodule

// File: rtl/wdt_clk_monitor_chk.sv
module wdt_clk_monitor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fault_i,
  input logic valid_i,
  input logic dis_i,
  input logic clr_pulse_i,
  input logic rise_i
);
  // R1
  always @(posedge clk_i)
    if (!rst_ni) reset_state_chk: assert (!fault_i && valid_i);

  // R2
  edge_revalidates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> valid_i);

  // R4
  timeout_sets_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !dis_i && !clr_pulse_i) |=> fault_i);

  // R5
  fault_latched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && !clr_pulse_i) |=> fault_i);

  // R6
  clear_releases_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_pulse_i |=> !fault_i);

  // R7
  disable_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_i && !fault_i) |=> !fault_i);
endmodule

bind wdt_clk_monitor wdt_clk_monitor_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fault_i    (wd_fault_o),
  .valid_i    (tmr_clk_valid_o),
  .dis_i      (wd_dis_i),
  .clr_pulse_i(clr_pulse),
  .rise_i     (wd_rise)
);

// File: tb/wdt_clk_monitor_bench.sv
module wdt_clk_monitor_bench;
  localparam int T = 40;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wd_clk = 1'b0, wd_dis = 1'b0, wd_clr = 1'b0;
  logic fault, valid;

  int cyc = 0;
  int n_chk = 0, n_err = 0;
  int last_rise = 0;
  bit done = 1'b0;

  typedef struct {
    int    due;
    bit    fault;
    bit    valid;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_clk_monitor #(.TIMEOUT_CYC(T)) u_wdt_clk_monitor (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .wd_clk_i       (wd_clk),
    .wd_dis_i       (wd_dis),
    .wd_clr_i       (wd_clr),
    .wd_fault_o     (fault),
    .tmr_clk_valid_o(valid)
  );

  task automatic expect_at(int due, bit f, bit v, string tag);
    exp_t e;
    e.due = due; e.fault = f; e.valid = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ref_pulse(bit f_exp, string tag);
    wd_clk = 1'b1;
    last_rise = cyc;
    expect_at(cyc + 3, f_exp, 1'b1, tag);
    step(5);
    wd_clk = 1'b0;
    step(5);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (e.due < cyc) begin
        n_err++;
        $display("FAIL %s: check for cycle %0d missed (now %0d)", e.tag, e.due, cyc);
      end else if (fault !== e.fault || valid !== e.valid) begin
        n_err++;
        $display("FAIL %s: cycle %0d fault=%b valid=%b expected fault=%b valid=%b",
                 e.tag, cyc, fault, valid, e.fault, e.valid);
      end
    end
  end

  initial begin
    int m;
    // reset
    step(3);
    n_chk++;
    if (fault !== 1'b0 || valid !== 1'b1) begin
      n_err++;
      $display("FAIL R1: in reset fault=%b valid=%b expected fault=0 valid=1", fault, valid);
    end
    rst_ni = 1'b1;
    expect_at(cyc + 1, 1'b0, 1'b1, "R1");
    step(1);

    // running reference
    for (int i = 0; i < 8; i++) ref_pulse(1'b0, "R2");

    // reference stops
    expect_at(last_rise + 2 + T, 1'b0, 1'b1, "R3");
    expect_at(last_rise + 3 + T, 1'b0, 1'b0, "R3");
    expect_at(last_rise + 4 + T, 1'b1, 1'b0, "R4");
    step(T + 2);

    // reference resumes, fault stays
    for (int i = 0; i < 4; i++) ref_pulse(1'b1, "R5");

    // clear held high then released
    wd_clr = 1'b1;
    expect_at(cyc + 1, 1'b1, 1'b1, "R6");
    expect_at(cyc + 3, 1'b1, 1'b1, "R6");
    step(4);
    wd_clr = 1'b0;
    expect_at(cyc + 1, 1'b0, 1'b1, "R6");
    step(1);
    for (int i = 0; i < 3; i++) ref_pulse(1'b0, "R6");

    // disabled, reference stops
    wd_dis = 1'b1;
    expect_at(last_rise + 3 + T, 1'b0, 1'b0, "R7");
    expect_at(last_rise + 4 + T, 1'b0, 1'b0, "R7");
    expect_at(last_rise + 12 + T, 1'b0, 1'b0, "R7");
    step(T + 8);

    // re-enable while expired
    wd_dis = 1'b0;
    expect_at(cyc + 1, 1'b1, 1'b0, "R4");
    step(3);
    wd_dis = 1'b1;
    expect_at(cyc + 1, 1'b1, 1'b0, "R8");
    expect_at(cyc + 6, 1'b1, 1'b0, "R8");
    step(8);
    wd_dis = 1'b0;
    step(2);

    // clear while reference absent
    wd_clr = 1'b1;
    step(2);
    wd_clr = 1'b0;
    m = cyc;
    expect_at(m + 1, 1'b0, 1'b1, "R9");
    expect_at(m + T, 1'b0, 1'b1, "R9");
    expect_at(m + 1 + T, 1'b0, 1'b0, "R9");
    expect_at(m + 2 + T, 1'b1, 1'b0, "R9");
    step(T + 6);

    while (q.size() > 0) step(1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: bench did not finish, actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule